// File: doc/BRIEF.md
# Fixed-Frequency Pulse Controller with Leading-Edge Masking

This block is a fixed-frequency digital pulse-width controller. A free-running cycle counter marks the start of each switching period with a forced-off interval. The drive pulse starts when that interval ends. It stops on the first qualifying trip flag from external comparators: a duty-compare trip, a current-limit trip or an overcurrent trip. The comparators are assumed to be synchronous to the block's clock.

The duty-compare and current-limit trips are masked for a programmable number of clocks after each pulse starts. This hides the switching spike at turn-on. The overcurrent trip is never masked. It cuts the drives in the same cycle and sets a sticky fault that only an explicit clear input removes.

A mode bit chooses between two output patterns. In the paired pattern both drives switch together. In the alternating pattern one pulse per period is steered to the two drives in turn. All timing values are counted in system clocks and take effect only at a period boundary.

Top module: `pwm_blank_ctrl`

## Requirements
- R1: In every period the two drives are low while the in-period position k satisfies k < De, where De = max(cfg_dead, 1).
- R2: A pulse goes high at k = De and stays high up to, but not including, the first cycle k in which a kill condition holds. Once low, it stays low until the next period. The kill conditions are an unmasked duty trip, an unmasked current trip, an overcurrent trip, or a set fault.
- R3: With cfg_alt = 0 latched for the period, drv_a and drv_b are equal in every cycle.
- R4: With cfg_alt = 1 latched, the pulse goes to drv_a in even periods and to drv_b in odd periods. Periods are counted from 0, starting with the first period after reset. The other drive stays low.
- R5: pwm_trip is ignored while k - De < Lb, where Lb is the latched cfg_blank. Lb = 0 means no masking.
- R6: ilim_trip is masked by the same window as pwm_trip and, once the window has ended, it ends the pulse in the cycle it is high.
- R7: ocp_trip forces both drives low in the same cycle, whatever the mask window. fault reads 1 from the next cycle on.
- R8: While fault is 1, no pulse starts. fault_clr clears fault in the next cycle only if ocp_trip is low in the same cycle; a set wins over a clear. A pulse starts at k = De only if fault and ocp_trip are both low in cycle k = De - 1.
- R9: cfg_period, cfg_dead, cfg_blank and cfg_alt are sampled only at the first period after reset and at each period wrap. The period length is Pe = max(cfg_period, 2) clocks.
- R10: If the mask window outlasts the period, the pulse ends only at the period wrap.
- R11: While reset is held, and in the first clock after its release, both drives and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | Period length in clocks |
| cfg_dead | input | CNT_W | Forced-off interval at each period start |
| cfg_blank | input | CNT_W | Mask window length after pulse start |
| cfg_alt | input | 1 | 1 = alternating outputs, 0 = paired outputs |
| pwm_trip | input | 1 | Duty-compare trip flag |
| ilim_trip | input | 1 | Current-limit trip flag |
| ocp_trip | input | 1 | Overcurrent trip flag, never masked |
| fault_clr | input | 1 | Request to clear the fault latch |
| drv_a | output | 1 | Drive output A |
| drv_b | output | 1 | Drive output B |
| fault | output | 1 | Fault latch state |

## Verification
Some properties are checked on every cycle by the assertions:
- low drives during the forced-off interval;
- equal drives in paired mode and exclusive drives in alternating mode;
- an overcurrent trip cutting the drives at once and then setting the latch;
- the latch's set, hold and clear rules;
- a live pulse surviving trips while the mask window is open;
- the counter staying inside the period.

Other behaviour only the bench's sweeps can show:
- the exact cycle in which each pulse starts and ends, for every combination of period, interval, mask length and trip position;
- the even/odd steering order;
- configuration taking effect only at a wrap;
- a mask window running past the wrap.

// File: rtl/pwm_blank_pkg.sv
package pwm_blank_pkg;

  // Period length actually used: at least two clocks so one can be live.
  function automatic int unsigned eff_period(input int unsigned p);
    return (p < 2) ? 2 : p;
  endfunction

  // Forced-off interval actually used: at least one clock.
  function automatic int unsigned eff_dead(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // Mask window test: offset since pulse start compared with window length.
  function automatic bit in_window(input int unsigned offs, input int unsigned len);
    return offs < len;
  endfunction

endpackage

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer
  import pwm_blank_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_dead,
  input  logic [CNT_W-1:0] cfg_blank,
  input  logic             cfg_alt,
  output logic [CNT_W-1:0] pos_q,
  output logic [CNT_W-1:0] dead_q,
  output logic [CNT_W-1:0] blank_q,
  output logic             alt_q,
  output logic             sel_q,
  output logic             wrap_ev,
  output logic             start_ev
);

  logic [CNT_W-1:0] per_q;
  logic             run_q;
  logic             load_ev;

  assign wrap_ev  = run_q && (pos_q == per_q - CNT_W'(1));
  assign load_ev  = !run_q || wrap_ev;
  // Pulse arms at the edge that ends the last forced-off clock.
  assign start_ev = run_q && !wrap_ev && (pos_q == dead_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pos_q   <= '0;
      per_q   <= CNT_W'(2);
      dead_q  <= CNT_W'(1);
      blank_q <= '0;
      alt_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load_ev) begin
        pos_q   <= '0;
        per_q   <= CNT_W'(eff_period(32'(cfg_period)));
        dead_q  <= CNT_W'(eff_dead(32'(cfg_dead)));
        blank_q <= cfg_blank;
        alt_q   <= cfg_alt;
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
      if (wrap_ev) sel_q <= ~sel_q;
    end
  end

  p_pos_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < per_q);

  p_cfg_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap_ev) |=> ($stable(dead_q) && $stable(blank_q) && $stable(alt_q)));

endmodule

// File: rtl/pwm_leb_timer.sv
module pwm_leb_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             mask_on
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 left_q <= '0;
    else if (load)              left_q <= len;
    else if (left_q != '0)      left_q <= left_q - CNT_W'(1);
  end

  assign mask_on = (left_q != '0);

  p_leb_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_on == (len != '0) || $past(len) != '0) );

  p_leb_counts_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !mask_on) |=> !mask_on);

endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ocp,
  input  logic clr,
  output logic fault_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_q <= 1'b0;
    else if (ocp)      fault_q <= 1'b1;
    else if (clr)      fault_q <= 1'b0;
  end

  p_ocp_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ocp |=> fault_q);

  p_fault_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> fault_q);

  p_fault_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && clr && !ocp) |=> !fault_q);

endmodule

// File: rtl/pwm_blank_ctrl.sv
module pwm_blank_ctrl
  import pwm_blank_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_dead,
  input  logic [CNT_W-1:0] cfg_blank,
  input  logic             cfg_alt,
  input  logic             pwm_trip,
  input  logic             ilim_trip,
  input  logic             ocp_trip,
  input  logic             fault_clr,
  output logic             drv_a,
  output logic             drv_b,
  output logic             fault
);

  logic [CNT_W-1:0] pos_q, dead_q, blank_q;
  logic             alt_q, sel_q, wrap_ev, start_ev;
  logic             mask_on, fault_q;
  logic             live_q, kill_now, soft_trip, pulse_on;

  pwm_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_dead(cfg_dead),
    .cfg_blank(cfg_blank), .cfg_alt(cfg_alt),
    .pos_q(pos_q), .dead_q(dead_q), .blank_q(blank_q),
    .alt_q(alt_q), .sel_q(sel_q),
    .wrap_ev(wrap_ev), .start_ev(start_ev)
  );

  pwm_leb_timer #(.CNT_W(CNT_W)) u_leb (
    .clk(clk), .rst_n(rst_n),
    .load(start_ev), .len(blank_q),
    .mask_on(mask_on)
  );

  pwm_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n),
    .ocp(ocp_trip), .clr(fault_clr),
    .fault_q(fault_q)
  );

  // Named events for the checks below.
  assign soft_trip = !mask_on && (pwm_trip || ilim_trip);
  assign kill_now  = ocp_trip || fault_q || soft_trip;
  assign pulse_on  = live_q && !kill_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= (start_ev && !fault_q && !ocp_trip) ||
                          (live_q && !kill_now && !wrap_ev);
  end

  always_comb begin
    drv_a = pulse_on && (!alt_q || !sel_q);
    drv_b = pulse_on && (!alt_q ||  sel_q);
  end

  assign fault = fault_q;

  p_dead_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q < dead_q) |-> (!drv_a && !drv_b));

  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_q && !start_ev) |=> !live_q);

  p_paired_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_q |-> (drv_a == drv_b));

  p_alt_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q |-> !(drv_a && drv_b));

  p_masked_survives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && mask_on && !ocp_trip && !fault_q) |-> (drv_a || drv_b));

  p_ocp_cuts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_trip |-> (!drv_a && !drv_b));

  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!drv_a && !drv_b));

  p_wrap_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> !live_q);

endmodule

// File: tb/tb_pwm_blank_ctrl.sv
module tb_pwm_blank_ctrl;
  localparam int W = 8;
  localparam int NONE = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cfg_period = '0, cfg_dead = '0, cfg_blank = '0;
  logic cfg_alt = 1'b0, pwm_trip = 1'b0, ilim_trip = 1'b0, ocp_trip = 1'b0, fault_clr = 1'b0;
  logic drv_a, drv_b, fault;

  int n_chk = 0, n_fail = 0;
  int cur_p, cur_d, cur_b, per_idx;
  bit cur_alt, fault_m;

  always #10 clk = ~clk;

  pwm_blank_ctrl #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_dead(cfg_dead),
    .cfg_blank(cfg_blank), .cfg_alt(cfg_alt), .pwm_trip(pwm_trip),
    .ilim_trip(ilim_trip), .ocp_trip(ocp_trip), .fault_clr(fault_clr),
    .drv_a(drv_a), .drv_b(drv_b), .fault(fault)
  );

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s period %0d: got %0b expected %0b", tag, what, per_idx, act, exp);
    end
  endtask

  function automatic bit fault_at(bit prior, bit clr, int ocp_pos, int k);
    return (prior && !(clr && ocp_pos != 0 && k >= 1)) || (ocp_pos < k);
  endfunction

  // One period. Checked with the latched config; drives the next one.
  task automatic run_period(input int np, input int nd, input int nb, input bit nalt,
                            input int pwm_pos, input int ilim_pos, input int ocp_pos,
                            input bit clr, input string tag);
    int pe, de, kp;
    bit allowed, sel, on, fk;
    pe = (cur_p < 2) ? 2 : cur_p;
    de = (cur_d == 0) ? 1 : cur_d;
    sel = per_idx[0];
    kp = pe;
    if (pwm_pos < pe)  kp = (kp < ((pwm_pos > de + cur_b) ? pwm_pos : de + cur_b)) ? kp : ((pwm_pos > de + cur_b) ? pwm_pos : de + cur_b);
    if (ilim_pos < pe) kp = (kp < ((ilim_pos > de + cur_b) ? ilim_pos : de + cur_b)) ? kp : ((ilim_pos > de + cur_b) ? ilim_pos : de + cur_b);
    if (ocp_pos >= de && ocp_pos < kp) kp = ocp_pos;
    allowed = !fault_at(fault_m, clr, ocp_pos, de - 1) && (ocp_pos != de - 1);
    cfg_period = W'(np); cfg_dead = W'(nd); cfg_blank = W'(nb); cfg_alt = nalt;
    for (int k = 0; k < pe; k++) begin
      pwm_trip  = (k >= pwm_pos);
      ilim_trip = (k >= ilim_pos);
      ocp_trip  = (k == ocp_pos);
      fault_clr = clr && (k == 0);
      #2;
      on = allowed && (k >= de) && (k < kp);
      fk = fault_at(fault_m, clr, ocp_pos, k);
      if (k < de) begin
        chk(drv_a, 1'b0, "R1", "drv_a in off interval");
        chk(drv_b, 1'b0, "R1", "drv_b in off interval");
      end else if (cur_alt) begin
        chk(sel ? drv_b : drv_a, on, tag, "steered drive");
        chk(sel ? drv_a : drv_b, 1'b0, "R4", "idle drive");
      end else begin
        chk(drv_a, on, tag, "drv_a");
        chk(drv_b, drv_a, "R3", "paired drives");
      end
      chk(fault, fk, (ocp_pos < pe) ? "R7" : "R8", "fault");
      @(negedge clk);
    end
    pwm_trip = 1'b0; ilim_trip = 1'b0; ocp_trip = 1'b0; fault_clr = 1'b0;
    fault_m = fault_at(fault_m, clr, ocp_pos, pe);
    cur_p = np; cur_d = nd; cur_b = nb; cur_alt = nalt;
    per_idx++;
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    cur_p = 5; cur_d = 1; cur_b = 0; cur_alt = 1'b0; fault_m = 1'b0; per_idx = 0;
    cfg_period = W'(cur_p); cfg_dead = W'(cur_d); cfg_blank = W'(cur_b); cfg_alt = cur_alt;
    repeat (3) @(negedge clk);
    chk(drv_a, 1'b0, "R11", "drv_a in reset");
    chk(drv_b, 1'b0, "R11", "drv_b in reset");
    chk(fault, 1'b0, "R11", "fault in reset");
    rst_n = 1'b1;
    #2;
    chk(drv_a | drv_b, 1'b0, "R11", "drives before first edge");
    @(negedge clk);

    // Sweep of period, interval, mask and duty trip position in both modes.
    for (int m = 0; m < 2; m++)
      for (int p = 0; p <= 6; p++)
        for (int d = 0; d <= 3; d++)
          for (int b = 0; b <= 3; b++) begin
            int pe;
            pe = (p < 2) ? 2 : p;
            run_period(p, d, b, m[0], 0, NONE, NONE, 1'b0, "R9");
            for (int pos = 0; pos <= pe; pos++)
              run_period(p, d, b, m[0], (pos == pe) ? NONE : pos, NONE, NONE, 1'b0,
                         (b > 0) ? "R5" : (m[0] ? "R4" : "R2"));
          end

    // Current-limit trip through the same mask window.
    run_period(8, 2, 0, 1'b0, NONE, NONE, NONE, 1'b0, "R9");
    for (int b = 0; b <= 5; b++) begin
      run_period(8, 2, b, 1'b0, NONE, NONE, NONE, 1'b0, "R9");
      for (int pos = 0; pos <= 8; pos++)
        run_period(8, 2, b, 1'b0, NONE, (pos == 8) ? NONE : pos, NONE, 1'b0, "R6");
    end

    // Mask window longer than the period.
    run_period(6, 1, 10, 1'b0, NONE, NONE, NONE, 1'b0, "R9");
    run_period(6, 1, 10, 1'b0, 0, 0, NONE, 1'b0, "R10");
    run_period(6, 1, 10, 1'b0, 0, NONE, NONE, 1'b0, "R10");

    // Overcurrent and the fault latch.
    run_period(8, 2, 3, 1'b0, NONE, NONE, NONE, 1'b0, "R9");
    run_period(8, 2, 3, 1'b0, NONE, NONE, 3, 1'b0, "R7");
    run_period(8, 2, 3, 1'b0, NONE, NONE, NONE, 1'b0, "R8");
    run_period(8, 2, 3, 1'b0, NONE, NONE, 0, 1'b1, "R8");
    run_period(8, 2, 3, 1'b0, NONE, NONE, NONE, 1'b1, "R8");
    run_period(8, 2, 3, 1'b1, NONE, NONE, 0, 1'b0, "R7");
    run_period(8, 1, 3, 1'b1, NONE, NONE, NONE, 1'b1, "R8");
    run_period(8, 1, 3, 1'b1, NONE, NONE, NONE, 1'b1, "R8");
    run_period(8, 1, 0, 1'b0, 5, NONE, 6, 1'b0, "R7");
    run_period(8, 3, 0, 1'b0, NONE, NONE, NONE, 1'b1, "R8");
    run_period(8, 3, 0, 1'b0, 6, NONE, NONE, 1'b0, "R8");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule